// File: doc/BRIEF.md
# Dual-Source Power Path Arbiter

This block is the control logic that decides which of two power inputs, channel A or channel B, feeds a shared output node. It reads undervoltage and overvoltage comparator flags for each input, a mode select, a lock control, an OTG/channel-A enable, the sensed level of a bidirectional open-drain flag pin, a thermal-shutdown flag and a 1 ms tick. From these it drives the two channel switch enables, an output discharge enable, the reverse OTG path enable, a soft-start indicator and the pull-down of the flag pin. All durations are counted in ticks and are set by parameters.

In slave mode the host gates each channel directly. Channel A is gated by the OTG enable and channel B by the flag pin, which passes through a two-flop synchronizer first. In autonomous mode a state machine runs the selection. Its states are OFF, A, B, AB (both on), BBM (break-before-make), OTG_WAIT and OTG. The transitions are:

- OFF→OTG_WAIT on an OTG request; otherwise OFF→A when A is valid, or OFF→B when B is valid. A wins when both are valid.
- A→BBM when A is lost and B is valid; A→OFF when A is lost and B is not.
- B→OTG_WAIT on an OTG request.
- B→BBM when A is valid and the lock is low, or when B is lost and A is valid; B→OFF when B is lost and A is not.
- B→AB when the flag pin reads low once it has settled.
- AB→B when the flag pin is released; AB→A when B is lost and A is valid; AB→OFF when both are lost.
- BBM→A or BBM→B (its target) when the timer expires, or BBM→OFF if the target is no longer valid.
- OTG_WAIT→OTG when the wait ends; OTG_WAIT→OFF when the OTG request drops.
- OTG→OFF when the OTG request drops.

Slave mode or thermal shutdown forces the state machine to OFF.

Top module: `pwr_src_arbiter`

## Requirements
- R1: After reset with the mode input low, both channel enables, the discharge enable, the reverse-path enable and the soft-start indicator are low, and the flag pull-down is on.
- R2: With the mode input high (slave), the channel A enable follows the OTG enable in the same cycle. The channel B enable follows the flag pin level two clock edges after the pin changes. Discharge and flag pull-down stay off.
- R3: A channel counts as valid only after its undervoltage flag is low and its overvoltage flag is low for A_DEB_TICKS ticks (channel A) or B_DEB_TICKS ticks (channel B). Leaving that window restarts the count.
- R4: While either overvoltage flag is high, both channel enables and the reverse-path enable are low in that same cycle.
- R5: In autonomous mode with no valid channel, both enables are off. From OFF the arbiter goes to the valid channel, and channel A wins when both are valid.
- R6: With the lock low, a valid channel A takes the output from channel B, passing through BBM.
- R7: With the lock high, channel B keeps the output while it stays valid, even when channel A becomes valid.
- R8: In BBM both channels are off and discharge is on for BBM_TICKS ticks. Discharge is never on while a channel enable is on.
- R9: In autonomous mode the flag pull-down is off exactly while channel B is active (B or AB) and on in every other state.
- R10: In state B, a low level on the settled flag pin turns on channel A as well. Releasing the pin turns channel A off again.
- R11: An OTG request waits OTG_LONG_TICKS ticks if channel B is valid and OTG_SHORT_TICKS ticks otherwise. It then enables channel A and the reverse path, with soft start shown for SS_TICKS ticks. The flag stays pulled low throughout.
- R12: While thermal shutdown is high every path and the discharge are off. Operation resumes from OFF when it clears.
- R13: Losing channel A while channel B is valid moves the output to B through BBM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slave_mode_i | input | 1 | 1 = slave mode, 0 = autonomous |
| lock_i | input | 1 | 1 = keep first valid channel |
| otg_a_en_i | input | 1 | OTG request (autonomous) / channel A gate (slave) |
| flag_sense_i | input | 1 | Sensed level of the open-drain flag pin |
| a_uv_i | input | 1 | Channel A below undervoltage threshold |
| a_ov_i | input | 1 | Channel A above overvoltage threshold |
| b_uv_i | input | 1 | Channel B below undervoltage threshold |
| b_ov_i | input | 1 | Channel B above overvoltage threshold |
| tsd_i | input | 1 | Thermal shutdown active |
| tick_i | input | 1 | One-cycle 1 ms timebase pulse |
| path_a_en_o | output | 1 | Channel A switch enable |
| path_b_en_o | output | 1 | Channel B switch enable |
| dischg_en_o | output | 1 | Output discharge enable |
| otg_rev_en_o | output | 1 | Reverse path (output to A) enable |
| soft_start_o | output | 1 | Reverse-path soft start in progress |
| flag_pull_o | output | 1 | Flag pin pull-down |

## Verification
The hardest state to reach is AB. The bench must first bring channel B up through its debounce and the break-before-make interval. It then has to let the released flag pin travel through the synchronizer, and only then pull the pin low. The pin is modelled as a wired-AND of the block's own pull-down and an external pull, and the external pull is asserted only after B has held for several cycles. The long OTG wait needs a similar setup: B is made valid and active first, so that the OTG request leaves state B with B still valid.

// File: rtl/pwr_arb_pkg.sv
package pwr_arb_pkg;
    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_A        = 3'd1,
        ST_B        = 3'd2,
        ST_AB       = 3'd3,
        ST_BBM      = 3'd4,
        ST_OTG_WAIT = 3'd5,
        ST_OTG      = 3'd6
    } arb_state_e;

    // cycles in B before the sensed flag level is trusted
    localparam int FLAG_SETTLE = 3;

    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction
endpackage

// File: rtl/pwr_arb_debounce.sv
module pwr_arb_debounce #(
    parameter int HOLD_TICKS = 15
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic in_window_i,
    input  logic tick_i,
    output logic valid_o
);
    localparam int CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] HOLD = CW'(HOLD_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            cnt_q <= '0;
        else if (!in_window_i)
            cnt_q <= '0;
        else if (tick_i && cnt_q != HOLD)
            cnt_q <= cnt_q + 1'b1;
    end

    assign valid_o = (cnt_q == HOLD);
endmodule

// File: rtl/pwr_arb_sync2.sv
module pwr_arb_sync2 (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic s1_q, s2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/pwr_arb_timer.sv
module pwr_arb_timer #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         tick_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (tick_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_src_arbiter.sv
module pwr_src_arbiter
    import pwr_arb_pkg::*;
#(
    parameter int A_DEB_TICKS     = 15,
    parameter int B_DEB_TICKS     = 1,
    parameter int BBM_TICKS       = 30,
    parameter int OTG_LONG_TICKS  = 10,
    parameter int OTG_SHORT_TICKS = 1,
    parameter int SS_TICKS        = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic slave_mode_i,
    input  logic lock_i,
    input  logic otg_a_en_i,
    input  logic flag_sense_i,
    input  logic a_uv_i,
    input  logic a_ov_i,
    input  logic b_uv_i,
    input  logic b_ov_i,
    input  logic tsd_i,
    input  logic tick_i,
    output logic path_a_en_o,
    output logic path_b_en_o,
    output logic dischg_en_o,
    output logic otg_rev_en_o,
    output logic soft_start_o,
    output logic flag_pull_o
);
    localparam int TMAX  = imax(imax(BBM_TICKS, SS_TICKS), imax(OTG_LONG_TICKS, OTG_SHORT_TICKS));
    localparam int TMR_W = $clog2(TMAX + 1);

    arb_state_e st_q, st_n;
    logic       tgt_a_q, tgt_a_n;
    logic [1:0] rel_q;
    logic [1:0] in_win, chan_ok;
    logic       flag_s, tmr_zero, tmr_load, kill;
    logic [TMR_W-1:0] tmr_val;
    logic       va, vb;

    assign in_win = {~b_uv_i & ~b_ov_i, ~a_uv_i & ~a_ov_i};

    for (genvar g = 0; g < 2; g++) begin : g_qual
        localparam int HOLD = (g == 0) ? A_DEB_TICKS : B_DEB_TICKS;
        pwr_arb_debounce #(.HOLD_TICKS(HOLD)) u_deb (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .in_window_i(in_win[g]),
            .tick_i     (tick_i),
            .valid_o    (chan_ok[g])
        );
    end

    assign va = chan_ok[0];
    assign vb = chan_ok[1];

    pwr_arb_sync2 u_flag_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (flag_sense_i),
        .q_o   (flag_s)
    );

    pwr_arb_timer #(.W(TMR_W)) u_tmr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .tick_i    (tick_i),
        .zero_o    (tmr_zero)
    );

    // next-state logic
    always_comb begin
        st_n    = st_q;
        tgt_a_n = tgt_a_q;
        if (slave_mode_i || tsd_i) begin
            st_n = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    if (otg_a_en_i)  st_n = ST_OTG_WAIT;
                    else if (va)     st_n = ST_A;
                    else if (vb)     st_n = ST_B;
                end
                ST_A: begin
                    if (!va) begin
                        if (vb) begin st_n = ST_BBM; tgt_a_n = 1'b0; end
                        else    st_n = ST_OFF;
                    end
                end
                ST_B: begin
                    if (otg_a_en_i) begin
                        st_n = ST_OTG_WAIT;
                    end else if (!vb) begin
                        if (va) begin st_n = ST_BBM; tgt_a_n = 1'b1; end
                        else    st_n = ST_OFF;
                    end else if (va && !lock_i) begin
                        st_n = ST_BBM; tgt_a_n = 1'b1;
                    end else if (rel_q == 2'(FLAG_SETTLE) && !flag_s) begin
                        st_n = ST_AB;
                    end
                end
                ST_AB: begin
                    if (!vb)         st_n = va ? ST_A : ST_OFF;
                    else if (flag_s) st_n = ST_B;
                end
                ST_BBM: begin
                    if (tmr_zero) begin
                        if (tgt_a_q) st_n = va ? ST_A : ST_OFF;
                        else         st_n = vb ? ST_B : ST_OFF;
                    end
                end
                ST_OTG_WAIT: begin
                    if (!otg_a_en_i)   st_n = ST_OFF;
                    else if (tmr_zero) st_n = ST_OTG;
                end
                ST_OTG: begin
                    if (!otg_a_en_i) st_n = ST_OFF;
                end
                default: st_n = ST_OFF;
            endcase
        end
    end

    assign tmr_load = (st_n != st_q);

    always_comb begin
        unique case (st_n)
            ST_BBM:      tmr_val = TMR_W'(BBM_TICKS);
            ST_OTG_WAIT: tmr_val = vb ? TMR_W'(OTG_LONG_TICKS) : TMR_W'(OTG_SHORT_TICKS);
            ST_OTG:      tmr_val = TMR_W'(SS_TICKS);
            default:     tmr_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q    <= ST_OFF;
            tgt_a_q <= 1'b0;
            rel_q   <= '0;
        end else begin
            st_q    <= st_n;
            tgt_a_q <= tgt_a_n;
            if (st_n != st_q)
                rel_q <= '0;
            else if (rel_q != 2'(FLAG_SETTLE))
                rel_q <= rel_q + 1'b1;
        end
    end

    // outputs
    assign kill = a_ov_i | b_ov_i | tsd_i;

    always_comb begin
        logic a, b, rev;
        a            = 1'b0;
        b            = 1'b0;
        rev          = 1'b0;
        dischg_en_o  = 1'b0;
        flag_pull_o  = 1'b0;
        if (slave_mode_i) begin
            a = otg_a_en_i;
            b = flag_s;
        end else begin
            unique case (st_q)
                ST_OFF:      flag_pull_o = 1'b1;
                ST_A:        begin a = 1'b1; flag_pull_o = 1'b1; end
                ST_B:        b = 1'b1;
                ST_AB:       begin a = 1'b1; b = 1'b1; end
                ST_BBM:      begin dischg_en_o = 1'b1; flag_pull_o = 1'b1; end
                ST_OTG_WAIT: flag_pull_o = 1'b1;
                ST_OTG:      begin a = 1'b1; rev = 1'b1; flag_pull_o = 1'b1; end
                default:     flag_pull_o = 1'b1;
            endcase
        end
        path_a_en_o  = a & ~kill;
        path_b_en_o  = b & ~kill;
        otg_rev_en_o = rev & ~kill;
        dischg_en_o  = dischg_en_o & ~tsd_i;
        soft_start_o = otg_rev_en_o & ~tmr_zero;
    end
endmodule

// File: rtl/pwr_arb_chk.sv
module pwr_arb_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic slave_mode_i,
    input logic a_ov_i,
    input logic b_ov_i,
    input logic tsd_i,
    input logic path_a_en_o,
    input logic path_b_en_o,
    input logic dischg_en_o,
    input logic otg_rev_en_o,
    input logic soft_start_o,
    input logic flag_pull_o
);
    // R4: overvoltage drops every forward and reverse path in the same cycle
    a_r4_ov_kill: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_ov_i || b_ov_i) |-> (!path_a_en_o && !path_b_en_o && !otg_rev_en_o));

    // R8: discharge never overlaps a conducting channel
    a_r8_dischg_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dischg_en_o |-> (!path_a_en_o && !path_b_en_o && !slave_mode_i));

    // R12: thermal shutdown turns everything off
    a_r12_tsd_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tsd_i |-> (!path_a_en_o && !path_b_en_o && !otg_rev_en_o && !dischg_en_o));

    // R2: slave mode never pulls the flag or discharges
    a_r2_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slave_mode_i |-> (!flag_pull_o && !dischg_en_o));

    // R9: flag released whenever channel B conducts in autonomous mode
    a_r9_flag_released_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!slave_mode_i && path_b_en_o) |-> !flag_pull_o);

    // R11: soft start only while the reverse path is on
    a_r11_ss_in_otg: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_start_o |-> otg_rev_en_o);

    // R6: no direct hand-over from B alone to A alone
    a_r6_no_direct_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!slave_mode_i && $past(!slave_mode_i) && $past(path_b_en_o && !path_a_en_o))
        |-> !(path_a_en_o && !path_b_en_o));
endmodule

bind pwr_src_arbiter pwr_arb_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slave_mode_i(slave_mode_i),
    .a_ov_i      (a_ov_i),
    .b_ov_i      (b_ov_i),
    .tsd_i       (tsd_i),
    .path_a_en_o (path_a_en_o),
    .path_b_en_o (path_b_en_o),
    .dischg_en_o (dischg_en_o),
    .otg_rev_en_o(otg_rev_en_o),
    .soft_start_o(soft_start_o),
    .flag_pull_o (flag_pull_o)
);

// File: tb/tb_pwr_src_arbiter.sv
`timescale 1ns/1ps
module tb_pwr_src_arbiter;
    localparam int A_DEB = 5, B_DEB = 2, BBM = 4, OLONG = 6, OSHORT = 2, SS = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode = 1'b0, lock = 1'b0, otg = 1'b0, ext_low = 1'b0;
    logic a_uv = 1'b1, a_ov = 1'b0, b_uv = 1'b1, b_ov = 1'b0, tsd = 1'b0;
    logic tick;
    logic pa, pb, dis, rev, ss, pull;
    logic flag_pin;
    int   tcnt = 0;
    int   checks = 0, fails = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    assign tick = (tcnt == 3);
    assign flag_pin = ~(pull | ext_low);

    pwr_src_arbiter #(.A_DEB_TICKS(A_DEB), .B_DEB_TICKS(B_DEB), .BBM_TICKS(BBM),
                      .OTG_LONG_TICKS(OLONG), .OTG_SHORT_TICKS(OSHORT), .SS_TICKS(SS)) dut (
        .clk_i(clk), .rst_ni(rst_n), .slave_mode_i(mode), .lock_i(lock),
        .otg_a_en_i(otg), .flag_sense_i(flag_pin), .a_uv_i(a_uv), .a_ov_i(a_ov),
        .b_uv_i(b_uv), .b_ov_i(b_ov), .tsd_i(tsd), .tick_i(tick),
        .path_a_en_o(pa), .path_b_en_o(pb), .dischg_en_o(dis),
        .otg_rev_en_o(rev), .soft_start_o(ss), .flag_pull_o(pull));

    // ---------------- behavioural reference ----------------
    // states: 0 off, 1 A, 2 B, 3 both, 4 break, 5 otg wait, 6 otg
    int m_st, m_tmr, m_rel, m_ca, m_cb;
    bit m_tgt, m_s1, m_s2;
    logic e_a, e_b, e_d, e_o, e_s, e_p;

    always @* begin
        bit k;
        k = a_ov | b_ov | tsd;
        {e_a, e_b, e_d, e_o, e_p} = '0;
        if (mode) begin
            e_a = otg; e_b = m_s2;
        end else begin
            e_p = !(m_st == 2 || m_st == 3);
            e_a = (m_st == 1 || m_st == 3 || m_st == 6);
            e_b = (m_st == 2 || m_st == 3);
            e_d = (m_st == 4) && !tsd;
            e_o = (m_st == 6);
        end
        if (k) begin e_a = 0; e_b = 0; e_o = 0; end
        e_s = e_o && (m_tmr > 0);
    end

    always @(posedge clk or negedge rst_n) begin
        int nx, ld;
        bit va, vb, pin;
        if (!rst_n) begin
            m_st <= 0; m_tmr <= 0; m_rel <= 0; m_ca <= 0; m_cb <= 0;
            m_tgt <= 0; m_s1 <= 0; m_s2 <= 0;
        end else begin
            va = (m_ca == A_DEB);
            vb = (m_cb == B_DEB);
            pin = !(e_p || ext_low);
            nx = m_st;
            if (mode || tsd) nx = 0;
            else case (m_st)
                0: if (otg) nx = 5; else if (va) nx = 1; else if (vb) nx = 2;
                1: if (!va) begin if (vb) begin nx = 4; m_tgt <= 0; end else nx = 0; end
                2: if (otg) nx = 5;
                   else if (!vb) begin if (va) begin nx = 4; m_tgt <= 1; end else nx = 0; end
                   else if (va && !lock) begin nx = 4; m_tgt <= 1; end
                   else if (m_rel == 3 && !m_s2) nx = 3;
                3: if (!vb) nx = va ? 1 : 0; else if (m_s2) nx = 2;
                4: if (m_tmr == 0) nx = m_tgt ? (va ? 1 : 0) : (vb ? 2 : 0);
                5: if (!otg) nx = 0; else if (m_tmr == 0) nx = 6;
                6: if (!otg) nx = 0;
                default: nx = 0;
            endcase
            ld = (nx == 4) ? BBM : (nx == 5) ? (vb ? OLONG : OSHORT) : (nx == 6) ? SS : 0;
            if (nx != m_st) begin m_tmr <= ld; m_rel <= 0; end
            else begin
                if (tick && m_tmr > 0) m_tmr <= m_tmr - 1;
                if (m_rel < 3) m_rel <= m_rel + 1;
            end
            m_st <= nx;
            m_ca <= (!a_uv && !a_ov) ? ((tick && m_ca < A_DEB) ? m_ca + 1 : m_ca) : 0;
            m_cb <= (!b_uv && !b_ov) ? ((tick && m_cb < B_DEB) ? m_cb + 1 : m_cb) : 0;
            m_s1 <= pin;
            m_s2 <= m_s1;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) if (rst_n && !done) begin
        check("R5 path A vs model", pa, e_a);
        check("R5 path B vs model", pb, e_b);
        check("R8 discharge vs model", dis, e_d);
        check("R11 reverse vs model", rev, e_o);
        check("R11 soft start vs model", ss, e_s);
        check("R9 flag pull vs model", pull, e_p);
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic at_neg;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2); at_neg;
        check("R1 a off", pa, 0); check("R1 b off", pb, 0); check("R1 dis off", dis, 0);
        check("R1 rev off", rev, 0); check("R1 ss off", ss, 0); check("R1 pull on", pull, 1);

        step(1); a_uv = 0;
        step(8); at_neg; check("R3 A not yet valid", pa, 0);
        step(30); at_neg; check("R5 A selected", pa, 1); check("R9 pull in A", pull, 1);

        step(1); b_uv = 0;
        step(20); at_neg; check("R5 A kept", pa, 1); check("R5 B off", pb, 0);

        step(1); a_uv = 1;
        step(2); at_neg; check("R13 break dis", dis, 1); check("R8 a off", pa, 0); check("R8 b off", pb, 0);
        step(30); at_neg; check("R13 on B", pb, 1); check("R8 dis off", dis, 0); check("R9 released", pull, 0);

        step(1); a_uv = 0;
        step(10); at_neg; check("R3 B holds during A debounce", pb, 1);
        step(50); at_neg; check("R6 A took over", pa, 1); check("R6 B off", pb, 0);

        step(1); lock = 1; a_uv = 1;
        step(30); at_neg; check("R13 back on B", pb, 1);
        step(1); a_uv = 0;
        step(60); at_neg; check("R7 locked B", pb, 1); check("R7 A off", pa, 0);

        step(1); ext_low = 1;
        step(8); at_neg; check("R10 both on A", pa, 1); check("R10 both on B", pb, 1);
        step(1); ext_low = 0;
        step(8); at_neg; check("R10 A off again", pa, 0); check("R10 B on", pb, 1);

        step(1); b_ov = 1;
        at_neg; check("R4 B killed", pb, 0); check("R4 A off", pa, 0);
        step(30); b_ov = 0;
        step(40); at_neg; check("R5 A after B lost", pa, 1);
        step(1); a_ov = 1;
        at_neg; check("R4 A killed", pa, 0);
        step(2); a_ov = 0;
        step(60);

        step(1); tsd = 1;
        at_neg; check("R12 a off", pa, 0); check("R12 b off", pb, 0); check("R12 dis off", dis, 0);
        step(5); at_neg; check("R12 still off", pa | pb | rev, 0);
        step(1); tsd = 0;
        step(10); at_neg; check("R12 resumed A wins", pa, 1); check("R5 B not chosen", pb, 0);

        step(1); lock = 0; a_uv = 1; b_uv = 1;
        step(10); at_neg; check("R5 off a", pa, 0); check("R5 off b", pb, 0); check("R9 pull off-state", pull, 1);

        step(1); otg = 1;
        step(2); at_neg; check("R11 waiting", pa, 0);
        step(12); at_neg; check("R11 reverse on", rev, 1); check("R11 A on", pa, 1); check("R11 flag low", pull, 1);
        step(20); at_neg; check("R11 soft start done", ss, 0); check("R11 reverse held", rev, 1);
        step(1); otg = 0;
        step(2); at_neg; check("R11 reverse off", rev, 0);

        step(1); b_uv = 0;
        step(30); at_neg; check("R5 on B", pb, 1);
        step(1); otg = 1;
        step(14); at_neg; check("R11 long wait a", pa, 0); check("R11 long wait b", pb, 0);
        step(20); at_neg; check("R11 long reverse on", rev, 1);
        step(1); otg = 0;
        step(30);

        step(1); mode = 1; ext_low = 1;
        step(4); at_neg; check("R2 B gated off", pb, 0); check("R2 no pull", pull, 0); check("R2 no dis", dis, 0);
        step(1); otg = 1;
        at_neg; check("R2 A follows", pa, 1);
        step(1); ext_low = 0;
        step(1); at_neg; check("R2 B sync delay", pb, 0);
        step(1); at_neg; check("R2 B follows", pb, 1);
        step(1); a_ov = 1;
        at_neg; check("R4 slave A killed", pa, 0);
        step(2); a_ov = 0; otg = 0;
        step(4);

        done = 1'b1;
        summary;
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary;
            $finish;
        end
    end
endmodule